// File: doc/BRIEF.md
# Multi-Channel Phase-Aligned PWM Generator

This block drives a set of pulse-width-modulated outputs. Each channel has its own period, high time and start delay, and an enable. All channels take their timing from one shared alignment point, so the phase relationship between them stays fixed. A new alignment point is set by a trigger. The trigger can be a falling edge of an external sync line that follows a software arm pulse, or, in automatic mode, any falling edge of that line.

Configuration arrives through a plain write port: an address, a data word and a write enable. Timing values that are written go into holding registers. A channel only takes them up when the next alignment happens, so a period that is already running is never disturbed. On a trigger the block can either restart every channel at once, or let each running channel finish its current period and then restart all of them together. A further option chooses whether pulses begin at the alignment point or one period after it.

Top module: `pwm_align_top`

## Requirements
- R1: After the synchronous active-low reset, every output is low and every channel is idle. The soft-stop, start-at-trigger, immediate-realign and automatic-trigger controls take the values of the parameters SOFT_RST_DEF, START_AT_SYNC_DEF, FORCE_ALIGN_DEF and AUTO_SYNC_DEF. The default values are 0, 1, 1 and 1.
- R2: A write takes effect on the clock edge where wr_en is 1. The address map is as follows. Address 0 is control: bit 0 is soft stop, bit 1 is start-at-trigger, bit 2 is immediate realign and bit 3 is automatic trigger. Address 1 holds the enables, with bit c for channel c. Address 2+3c is the period of channel c, 3+3c is its high time and 4+3c is its start delay.
- R3: Period, high time and start delay written to a channel only take effect at the next alignment. Before the first alignment every channel stays low.
- R4: With an immediate realignment, a falling edge of ext_sync is seen at clock edge k. Every channel reloads at edge k+1. A channel's first cycle of a period begins after edge k+1+D, and its output is high for the first "high time" cycles of each period.
- R5: With automatic trigger off, a load_cfg pulse arms the block, and only the next falling edge of ext_sync after that causes an alignment. Falling edges while the block is not armed have no effect.
- R6: With automatic trigger on, every falling edge of ext_sync causes an alignment, and no arming is needed.
- R7: With immediate realign on, the alignment cuts off any pulse or period that is under way.
- R8: With immediate realign off, a trigger makes each running channel finish its current period and then stay low. A channel that is still waiting for its start goes idle. Once all channels are idle, the alignment follows on the next edge.
- R9: D is the start delay when start-at-trigger is 1. It is the start delay plus the channel's period when start-at-trigger is 0.
- R10: A disabled channel's output is low at all times.
- R11: A high time of 0 gives a constant low output. A high time equal to the period gives a constant high output with no low cycle at the wrap. A period of 0 keeps the channel idle and low.
- R12: While soft stop is 1, all outputs are low and all channels are cleared to idle. After soft stop is released, the channels stay low until the next alignment.
- R13: Falling edges of ext_sync that occur while a graceful realignment is draining are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_addr | input | AW | Register address (AW from the channel count) |
| wr_data | input | CW | Write data |
| load_cfg | input | 1 | Arm pulse for the armed trigger mode |
| ext_sync | input | 1 | External sync, already synchronous to clk |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
A write is visible from the edge that captures it. A falling edge of ext_sync is registered at edge k and reloads the channels at edge k+1 when realignment is immediate. In graceful mode the reload comes at the edge after the last channel goes idle, which is at least k+2. A channel then rises after edge k+1+D. The bench keeps a reference model of these rules, updated on every rising edge. It compares all outputs against the model at each falling edge, so every result is sampled half a period after the edge that produced it. Hand-timed checks count falling edges from the trigger edge to confirm the offset-only and offset-plus-period start delays.

// File: rtl/pwm_align_pkg.sv
// Shared constants and types for the phase-aligned PWM generator.
// Assumes: register addresses are word indices; channel registers repeat with a fixed stride.
package pwm_align_pkg;
    typedef enum logic [0:0] {AL_IDLE = 1'b0, AL_DRAIN = 1'b1} align_state_e;

    localparam int CTRL_ADDR = 0;
    localparam int EN_ADDR   = 1;
    localparam int CH_BASE   = 2;
    localparam int CH_STRIDE = 3;

    localparam int B_SOFT  = 0;
    localparam int B_SAS   = 1;
    localparam int B_FORCE = 2;
    localparam int B_AUTO  = 3;
endpackage

// File: rtl/pwm_cfg_regs.sv
// Configuration register file: control bits, channel enables and per-channel
// holding registers for period, high time and start delay.
// Assumes: NCH <= CW so the enable word fits in one data word.
module pwm_cfg_regs import pwm_align_pkg::*; #(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int AW  = 4,
    parameter bit SOFT_RST_DEF      = 1'b0,
    parameter bit START_AT_SYNC_DEF = 1'b1,
    parameter bit FORCE_ALIGN_DEF   = 1'b1,
    parameter bit AUTO_SYNC_DEF     = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [CW-1:0]           wr_data,
    output logic                    soft_rst,
    output logic                    start_at_sync,
    output logic                    force_mode,
    output logic                    auto_mode,
    output logic [NCH-1:0]          chan_en,
    output logic [NCH-1:0][CW-1:0]  period_sh,
    output logic [NCH-1:0][CW-1:0]  width_sh,
    output logic [NCH-1:0][CW-1:0]  offset_sh
);
    // Capture writes into control, enable and holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_rst      <= SOFT_RST_DEF;
            start_at_sync <= START_AT_SYNC_DEF;
            force_mode    <= FORCE_ALIGN_DEF;
            auto_mode     <= AUTO_SYNC_DEF;
            chan_en       <= '0;
            period_sh     <= '0;
            width_sh      <= '0;
            offset_sh     <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(CTRL_ADDR)) begin
                soft_rst      <= wr_data[B_SOFT];
                start_at_sync <= wr_data[B_SAS];
                force_mode    <= wr_data[B_FORCE];
                auto_mode     <= wr_data[B_AUTO];
            end
            if (wr_addr == AW'(EN_ADDR)) begin
                chan_en <= wr_data[NCH-1:0];
            end
            for (int c = 0; c < NCH; c++) begin
                if (wr_addr == AW'(CH_BASE + CH_STRIDE*c))     period_sh[c] <= wr_data;
                if (wr_addr == AW'(CH_BASE + CH_STRIDE*c + 1)) width_sh[c]  <= wr_data;
                if (wr_addr == AW'(CH_BASE + CH_STRIDE*c + 2)) offset_sh[c] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/pwm_align_ctrl.sv
// Alignment controller: detects sync falling edges, handles arming, and issues
// a one-cycle align pulse either at once or after all channels have drained.
// Assumes: ext_sync is already synchronous to clk.
module pwm_align_ctrl import pwm_align_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic auto_mode,
    input  logic force_mode,
    input  logic load_cfg,
    input  logic ext_sync,
    input  logic all_idle,
    output logic align,
    output logic stop_req
);
    align_state_e state;
    logic sync_q, armed, sync_fall, trig;

    // Keep last sync level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= ext_sync;
    end

    assign sync_fall = sync_q & ~ext_sync;
    assign trig      = sync_fall & (auto_mode | armed) & (state == AL_IDLE);
    assign stop_req  = (state == AL_DRAIN);

    // Arm, trigger and drain sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state <= AL_IDLE;
            armed <= 1'b0;
            align <= 1'b0;
        end else begin
            align <= 1'b0;
            if (load_cfg && !auto_mode) armed <= 1'b1;
            case (state)
                AL_IDLE: if (trig) begin
                    armed <= 1'b0;
                    if (force_mode) align <= 1'b1;
                    else            state <= AL_DRAIN;
                end
                AL_DRAIN: if (all_idle) begin
                    align <= 1'b1;
                    state <= AL_IDLE;
                end
                default: state <= AL_IDLE;
            endcase
        end
    end

    AST_ALIGN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        align |-> ($past(sync_fall) || $past(stop_req)));                       // R6
    AST_UNARMED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_mode && !armed && sync_fall && !stop_req && !soft_rst) |=> (!align && !stop_req)); // R5
    AST_DRAIN_NO_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !all_idle && !soft_rst) |=> (stop_req && !align));         // R13
endmodule

// File: rtl/pwm_chan.sv
// One PWM channel: on align it takes up its held settings, waits the start
// delay, then counts periods; under stop_req it finishes the period and idles.
// Assumes: align and stop_req are never high in the same cycle.
module pwm_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          align,
    input  logic          stop_req,
    input  logic          start_at_sync,
    input  logic          chan_en,
    input  logic [CW-1:0] period_sh,
    input  logic [CW-1:0] width_sh,
    input  logic [CW-1:0] offset_sh,
    output logic          pwm_o,
    output logic          idle_o
);
    localparam int DW = CW + 1;

    logic [CW-1:0] per_a, wid_a, cnt;
    logic [DW-1:0] wait_cnt, first_dly;
    logic          running, at_end;

    assign at_end    = (cnt == per_a - 1'b1);
    assign first_dly = DW'(offset_sh) + (start_at_sync ? '0 : DW'(period_sh));

    // Sequence the reload, start-delay, running and drain phases.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            per_a    <= '0;
            wid_a    <= '0;
            cnt      <= '0;
            wait_cnt <= '0;
            running  <= 1'b0;
        end else if (align) begin
            per_a <= period_sh;
            wid_a <= width_sh;
            cnt   <= '0;
            if (period_sh == '0) begin
                running  <= 1'b0;
                wait_cnt <= '0;
            end else if (first_dly == '0) begin
                running  <= 1'b1;
                wait_cnt <= '0;
            end else begin
                running  <= 1'b0;
                wait_cnt <= first_dly;
            end
        end else if (running) begin
            if (at_end) begin
                cnt <= '0;
                if (stop_req) running <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (stop_req) begin
            wait_cnt <= '0;
        end else if (wait_cnt != '0) begin
            if (wait_cnt == DW'(1)) begin
                running <= 1'b1;
                cnt     <= '0;
            end
            wait_cnt <= wait_cnt - 1'b1;
        end
    end

    assign pwm_o  = chan_en & running & (cnt < wid_a);
    assign idle_o = ~running & (wait_cnt == '0);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt < per_a));                                             // R4
    AST_DIS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |-> !pwm_o);                                                   // R10
    AST_ZERO_WIDTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wid_a == '0) |-> !pwm_o);                                              // R11
    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && idle_o && !align) |=> idle_o);                             // R8
endmodule

// File: rtl/pwm_align_top.sv
// Top level: register file, alignment controller and NCH channels.
// Soft stop gates all outputs low at once and clears the channels.
// Assumes: one clock domain; NCH <= CW.
module pwm_align_top import pwm_align_pkg::*; #(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter bit SOFT_RST_DEF      = 1'b0,
    parameter bit START_AT_SYNC_DEF = 1'b1,
    parameter bit FORCE_ALIGN_DEF   = 1'b1,
    parameter bit AUTO_SYNC_DEF     = 1'b1,
    localparam int AW = $clog2(CH_BASE + CH_STRIDE*NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [CW-1:0]  wr_data,
    input  logic           load_cfg,
    input  logic           ext_sync,
    output logic [NCH-1:0] pwm_out
);
    logic                   soft_rst, start_at_sync, force_mode, auto_mode;
    logic                   align, stop_req;
    logic [NCH-1:0]         chan_en, raw_pwm, idle_vec;
    logic [NCH-1:0][CW-1:0] period_sh, width_sh, offset_sh;

    pwm_cfg_regs #(
        .NCH(NCH), .CW(CW), .AW(AW),
        .SOFT_RST_DEF(SOFT_RST_DEF), .START_AT_SYNC_DEF(START_AT_SYNC_DEF),
        .FORCE_ALIGN_DEF(FORCE_ALIGN_DEF), .AUTO_SYNC_DEF(AUTO_SYNC_DEF)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .soft_rst(soft_rst), .start_at_sync(start_at_sync), .force_mode(force_mode),
        .auto_mode(auto_mode), .chan_en(chan_en), .period_sh(period_sh),
        .width_sh(width_sh), .offset_sh(offset_sh)
    );

    pwm_align_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .auto_mode(auto_mode),
        .force_mode(force_mode), .load_cfg(load_cfg), .ext_sync(ext_sync),
        .all_idle(&idle_vec), .align(align), .stop_req(stop_req)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pwm_chan #(.CW(CW)) u_chan (
            .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .align(align),
            .stop_req(stop_req), .start_at_sync(start_at_sync), .chan_en(chan_en[c]),
            .period_sh(period_sh[c]), .width_sh(width_sh[c]), .offset_sh(offset_sh[c]),
            .pwm_o(raw_pwm[c]), .idle_o(idle_vec[c])
        );
    end

    assign pwm_out = soft_rst ? '0 : raw_pwm;

    AST_SOFT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (pwm_out == '0));                                          // R12
endmodule

// File: tb/pwm_align_top_tb.sv
// Bench for pwm_align_top: a behavioural reference model, updated on each
// rising edge and compared on each falling edge, plus hand-timed checks.
module pwm_align_top_tb;
    localparam int NCH = 4;
    localparam int CW  = 16;
    localparam int AW  = $clog2(2 + 3*NCH);
    localparam bit D_SOFT = 1'b0, D_SAS = 1'b1, D_FORCE = 1'b1, D_AUTO = 1'b1;

    logic clk = 1'b0;
    logic rst_n, wr_en, load_cfg, ext_sync;
    logic [AW-1:0]  wr_addr;
    logic [CW-1:0]  wr_data;
    logic [NCH-1:0] pwm_out;

    int checks = 0, errors = 0, cyc = 0;
    bit cmp_on = 1'b0, done = 1'b0;
    string phase = "R1";

    always #2 clk = ~clk;

    pwm_align_top #(
        .NCH(NCH), .CW(CW), .SOFT_RST_DEF(D_SOFT), .START_AT_SYNC_DEF(D_SAS),
        .FORCE_ALIGN_DEF(D_FORCE), .AUTO_SYNC_DEF(D_AUTO)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .load_cfg(load_cfg), .ext_sync(ext_sync), .pwm_out(pwm_out)
    );

    // Reference model state
    int unsigned sh_per[NCH], sh_wid[NCH], sh_off[NCH];
    int unsigned a_per[NCH], a_wid[NCH], m_cnt[NCH], m_wt[NCH];
    bit m_run[NCH];
    bit m_soft, m_sas, m_force, m_auto, m_sq, m_armed, m_align, m_drain;
    bit [NCH-1:0] m_en;

    task automatic model_step();
        bit fall, all_idle, n_align, n_armed, n_drain;
        int unsigned d;
        if (!rst_n) begin
            m_soft = D_SOFT; m_sas = D_SAS; m_force = D_FORCE; m_auto = D_AUTO;
            m_sq = 0; m_armed = 0; m_align = 0; m_drain = 0; m_en = '0;
            for (int c = 0; c < NCH; c++) begin
                sh_per[c] = 0; sh_wid[c] = 0; sh_off[c] = 0;
                a_per[c] = 0; a_wid[c] = 0; m_cnt[c] = 0; m_wt[c] = 0; m_run[c] = 0;
            end
            return;
        end
        fall = m_sq && !ext_sync;
        all_idle = 1;
        for (int c = 0; c < NCH; c++) if (m_run[c] || m_wt[c] != 0) all_idle = 0;
        for (int c = 0; c < NCH; c++) begin
            if (m_soft) begin
                m_run[c] = 0; m_cnt[c] = 0; m_wt[c] = 0; a_per[c] = 0; a_wid[c] = 0;
            end else if (m_align) begin
                a_per[c] = sh_per[c]; a_wid[c] = sh_wid[c]; m_cnt[c] = 0;
                d = sh_off[c] + (m_sas ? 0 : sh_per[c]);
                if (sh_per[c] == 0) begin m_run[c] = 0; m_wt[c] = 0; end
                else if (d == 0)    begin m_run[c] = 1; m_wt[c] = 0; end
                else                begin m_run[c] = 0; m_wt[c] = d; end
            end else if (m_run[c]) begin
                if (m_cnt[c] + 1 == a_per[c]) begin
                    m_cnt[c] = 0;
                    if (m_drain) m_run[c] = 0;
                end else m_cnt[c]++;
            end else if (m_drain) begin
                m_wt[c] = 0;
            end else if (m_wt[c] != 0) begin
                if (m_wt[c] == 1) begin m_run[c] = 1; m_cnt[c] = 0; end
                m_wt[c]--;
            end
        end
        if (m_soft) begin
            m_armed = 0; m_align = 0; m_drain = 0;
        end else begin
            n_align = 0; n_armed = m_armed; n_drain = m_drain;
            if (load_cfg && !m_auto) n_armed = 1;
            if (!m_drain) begin
                if (fall && (m_auto || m_armed)) begin
                    n_armed = 0;
                    if (m_force) n_align = 1; else n_drain = 1;
                end
            end else if (all_idle) begin
                n_align = 1; n_drain = 0;
            end
            m_align = n_align; m_armed = n_armed; m_drain = n_drain;
        end
        m_sq = ext_sync;
        if (wr_en) begin
            if (wr_addr == 0) begin
                m_soft = wr_data[0]; m_sas = wr_data[1]; m_force = wr_data[2]; m_auto = wr_data[3];
            end
            if (wr_addr == 1) m_en = wr_data[NCH-1:0];
            for (int c = 0; c < NCH; c++) begin
                if (wr_addr == AW'(2 + 3*c)) sh_per[c] = wr_data;
                if (wr_addr == AW'(3 + 3*c)) sh_wid[c] = wr_data;
                if (wr_addr == AW'(4 + 3*c)) sh_off[c] = wr_data;
            end
        end
    endtask

    function automatic logic [NCH-1:0] model_out();
        logic [NCH-1:0] e;
        for (int c = 0; c < NCH; c++)
            e[c] = !m_soft && m_en[c] && m_run[c] && (m_cnt[c] < a_wid[c]);
        return e;
    endfunction

    task automatic chk(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) model_step();

    // Compare against the model on every falling edge.
    always @(negedge clk) if (cmp_on && rst_n) chk({phase, " model"}, pwm_out, model_out());

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk); wr_en = 1; wr_addr = AW'(a); wr_data = CW'(d);
        @(negedge clk); wr_en = 0;
    endtask

    task automatic wr_ch(input int c, input int p, input int w, input int o);
        wr(2 + 3*c, p); wr(3 + 3*c, w); wr(4 + 3*c, o);
    endtask

    // Leaves ext_sync low at a falling edge; the next rising edge is the trigger edge k.
    task automatic sync_fall();
        @(negedge clk); ext_sync = 1;
        @(negedge clk); ext_sync = 0;
    endtask

    initial begin
        rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0; load_cfg = 0; ext_sync = 1;
        repeat (5) @(negedge clk);
        rst_n = 1; cmp_on = 1;
        @(negedge clk); chk("R1 outputs low after reset", pwm_out, '0);

        phase = "R2";
        wr_ch(0, 10, 3, 2); wr_ch(1, 7, 2, 0); wr_ch(2, 5, 0, 1); wr_ch(3, 4, 4, 0);
        wr(1, 4'hF);
        repeat (3) @(negedge clk);
        chk("R3 low before first alignment", pwm_out, '0);

        phase = "R4";
        sync_fall();
        repeat (3) @(negedge clk);
        chk("R4 ch0 still in offset after edge k+2", {3'b000, pwm_out[0]}, 4'b0000);
        @(negedge clk);
        chk("R1 R4 ch0 rises after edge k+3", {3'b000, pwm_out[0]}, 4'b0001);
        chk("R11 ch3 full width high", {3'b000, pwm_out[3]}, 4'b0001);
        chk("R11 ch2 zero width low", {3'b000, pwm_out[2]}, 4'b0000);
        repeat (30) @(negedge clk);

        phase = "R10";
        wr(1, 4'hD);
        repeat (20) @(negedge clk);

        phase = "R3";
        wr_ch(0, 6, 2, 2);
        repeat (20) @(negedge clk);

        phase = "R9";
        wr(0, 4'b1100);
        sync_fall();
        repeat (9) @(negedge clk);
        chk("R9 ch0 waits offset plus period", {3'b000, pwm_out[0]}, 4'b0000);
        @(negedge clk);
        chk("R9 ch0 rises after edge k+9", {3'b000, pwm_out[0]}, 4'b0001);
        repeat (30) @(negedge clk);

        phase = "R8";
        wr(1, 4'hF);
        wr(0, 4'b1010);
        repeat (3) @(negedge clk);
        sync_fall();
        repeat (2) @(negedge clk);
        phase = "R13";
        sync_fall();
        repeat (60) @(negedge clk);

        phase = "R5";
        wr(0, 4'b0110);
        wr_ch(1, 0, 5, 0);
        sync_fall();
        repeat (15) @(negedge clk);
        @(negedge clk); load_cfg = 1;
        @(negedge clk); load_cfg = 0;
        repeat (5) @(negedge clk);
        phase = "R11";
        sync_fall();
        repeat (30) @(negedge clk);

        phase = "R6";
        wr(0, 4'b1110);
        wr_ch(1, 9, 4, 1);
        for (int i = 0; i < 3; i++) begin
            repeat (7) @(negedge clk);
            sync_fall();
        end
        phase = "R7";
        repeat (4) @(negedge clk);
        sync_fall();
        repeat (20) @(negedge clk);

        phase = "R12";
        wr(0, 4'b0111);
        repeat (10) @(negedge clk);
        chk("R12 soft stop holds outputs low", pwm_out, '0);
        wr(0, 4'b1110);
        repeat (10) @(negedge clk);
        chk("R12 idle until next alignment", pwm_out, '0);
        sync_fall();
        repeat (30) @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule